// File: doc/BRIEF.md
# Voltage Regulator Soft-Start Sequencer

This block brings the reference code of a voltage regulator's DAC up from zero after the regulator is enabled, and then signals that the output is ready. The code is counted in 6.25 mV units, so 176 stands for 1.1 V and 240 for 1.5 V.

The sequence has four phases. The first is a fixed wait. The second ramps the code up to an intermediate 1.1 V plateau, one code per step tick. The third holds at the plateau for a fixed time and then waits until the target code is flagged valid. The fourth ramps to the target, up or down, one code per tick. After the code reaches the target, a fixed post-delay runs and then the ready flag rises. All delays are clock-cycle counts set by parameters.

The step tick is a single-cycle pulse that comes from an external programmable divider. Until ready rises, the block overrides any request for a low-power mode and keeps the power stage in normal continuous-conduction PWM. Two events put the block back to zero at once: loss of enable, and a valid all-zero target code (the off code). After an off code, the block stays down until a fault-clear pulse or a loss of enable.

Top module: `vr_softstart_seq`

## Requirements
- R1: While reset is held, and while `enable` is low, `dacCode` is 0, `ready` is 0, `ssActive` is 0 and `forceCcm` is 1.
- R2: After the clock edge that first samples `enable` high, `dacCode` stays 0 for DELAY1_CYC cycles. The first increment lands on the edge DELAY1_CYC+2 after enable is sampled, provided `stepTick` is high on every cycle.
- R3: During either ramp, `dacCode` changes by exactly one code on each edge where `stepTick` is high. It never changes on an edge where `stepTick` is low.
- R4: The first ramp stops at PLAT_CODE (176, which is 1.1 V). The code then holds there while `vidValid` is low.
- R5: The second ramp cannot start earlier than HOLD_CYC cycles after the plateau is reached. The first step of the second ramp comes HOLD_CYC+2 edges after the plateau code appears, if the VID is already valid and ticks run every cycle.
- R6: The second ramp moves `dacCode` toward `vidCode` in either direction and stops when the two are equal.
- R7: If `vidValid` is high and `vidCode` is below PLAT_CODE during the first ramp, that ramp ends at `vidCode` and the second ramp takes zero steps. In that case `ready` rises HOLD_CYC+READY_CYC+2 edges after the target code appears.
- R8: `ready` rises exactly READY_CYC+1 edges after the edge on which `dacCode` first equals the target in the second ramp.
- R9: `lowPwrMode` follows `psiReq` only while `ready` is high and is 0 otherwise. `forceCcm` is the inverse of `ready`.
- R10: In a sequencing state, a valid off code (`vidValid` high, `vidCode` 0) forces `dacCode` to 0 and `ready` and `ssActive` to 0 on the next edge, even when a step tick arrives in the same cycle. The block stays there until `faultClr` is pulsed, and then restarts.
- R11: Loss of `enable` in any state returns the block to idle on the next edge, with `dacCode` 0 and `ready` 0.
- R12: `ssActive` is 1 from the edge that samples `enable` high until `ready` rises, and 0 while `ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Regulator enable; low restarts the sequence |
| vidValid | input | 1 | Target code is valid |
| vidCode | input | CODE_W | Target code in 6.25 mV units; 0 is the off code |
| stepTick | input | 1 | Single-cycle ramp step pulse from the divider |
| faultClr | input | 1 | Releases the off-code latch |
| psiReq | input | 1 | Request for the low-power mode |
| dacCode | output | CODE_W | Reference DAC code |
| ready | output | 1 | Soft start complete and output in range |
| ssActive | output | 1 | Soft start in progress |
| forceCcm | output | 1 | Forces normal continuous-conduction PWM |
| lowPwrMode | output | 1 | Low-power mode request passed on once ready |

## Verification
The collision of interest is an off code that arrives in the same cycle as a ramp step tick. Both want to change `dacCode`, one by adding a code and the other by clearing it. The bench holds `stepTick` high on every cycle and drops `vidCode` to zero partway through the first ramp. It then expects `dacCode` to read exactly 0 after the very next edge, not the previous value plus one. It also checks that the code stays at zero after the off code is withdrawn, and that the sequence restarts only after a `faultClr` pulse.

// File: rtl/ss_pkg.sv
package ss_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DELAY,
    S_RAMP1,
    S_HOLD,
    S_RAMP2,
    S_POST,
    S_READY,
    S_OFF
  } seqState_t;

  typedef enum logic [1:0] {
    CNT_DELAY,
    CNT_HOLD,
    CNT_POST
  } cntSel_t;

  typedef struct packed {
    logic    clearDac;
    logic    stepUp;
    logic    stepDown;
    logic    loadCnt;
    cntSel_t cntSel;
  } ssStrobe_t;

endpackage

// File: rtl/ss_datapath.sv
module ss_datapath
  import ss_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int DELAY1_CYC = 136000,
  parameter int HOLD_CYC   = 8500,
  parameter int READY_CYC  = 8500,
  parameter int PLAT_CODE  = 176
) (
  input  logic              clk,
  input  logic              rstN,
  input  ssStrobe_t         strobe,
  input  logic              vidValid,
  input  logic [CODE_W-1:0] vidCode,
  output logic [CODE_W-1:0] dacCode,
  output logic              cntZero,
  output logic              atPlateau,
  output logic              atTarget,
  output logic              belowTarget,
  output logic              offCode
);

  localparam int MAX_A  = (DELAY1_CYC > HOLD_CYC) ? DELAY1_CYC : HOLD_CYC;
  localparam int MAX_C  = (MAX_A > READY_CYC) ? MAX_A : READY_CYC;
  localparam int CNT_W  = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0]  DELAY_LOAD = CNT_W'(DELAY1_CYC - 1);
  localparam logic [CNT_W-1:0]  HOLD_LOAD  = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0]  POST_LOAD  = CNT_W'(READY_CYC - 1);
  localparam logic [CODE_W-1:0] PLAT       = CODE_W'(PLAT_CODE);

  logic [CNT_W-1:0]  dlyCnt;
  logic [CNT_W-1:0]  loadVal;
  logic [CODE_W-1:0] rampLimit;

  // The first ramp ends at the plateau, or lower if a valid target sits below it.
  always_comb begin
    rampLimit = PLAT;
    if (vidValid && (vidCode < PLAT)) rampLimit = vidCode;
  end

  assign atPlateau   = (dacCode >= rampLimit);
  assign atTarget    = (dacCode == vidCode);
  assign belowTarget = (dacCode < vidCode);
  assign offCode     = vidValid && (vidCode == '0);
  assign cntZero     = (dlyCnt == '0);

  always_comb begin
    case (strobe.cntSel)
      CNT_DELAY: loadVal = DELAY_LOAD;
      CNT_HOLD:  loadVal = HOLD_LOAD;
      default:   loadVal = POST_LOAD;
    endcase
  end

  // Shared loadable down-counter for the three timed phases.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dlyCnt <= '0;
    end else if (strobe.loadCnt) begin
      dlyCnt <= loadVal;
    end else if (dlyCnt != '0) begin
      dlyCnt <= dlyCnt - CNT_W'(1);
    end
  end

  // DAC code register: a clear always wins over a step.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dacCode <= '0;
    end else if (strobe.clearDac) begin
      dacCode <= '0;
    end else if (strobe.stepUp) begin
      dacCode <= dacCode + CODE_W'(1);
    end else if (strobe.stepDown) begin
      dacCode <= dacCode - CODE_W'(1);
    end
  end

  // R3: the code moves by at most one step per cycle unless it is cleared
  step_size_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clearDac |=> (dacCode == $past(dacCode)) ||
                         (dacCode == $past(dacCode) + CODE_W'(1)) ||
                         (dacCode == $past(dacCode) - CODE_W'(1)));

endmodule

// File: rtl/ss_ctrl.sv
module ss_ctrl
  import ss_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int PLAT_CODE = 176
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              vidValid,
  input  logic              stepTick,
  input  logic              faultClr,
  input  logic              psiReq,
  input  logic              cntZero,
  input  logic              atPlateau,
  input  logic              atTarget,
  input  logic              belowTarget,
  input  logic              offCode,
  input  logic [CODE_W-1:0] dacCode,
  output ssStrobe_t         strobe,
  output logic              ready,
  output logic              ssActive,
  output logic              forceCcm,
  output logic              lowPwrMode
);

  seqState_t state, nextState;
  logic      seqBusy;

  assign seqBusy = (state != S_IDLE) && (state != S_OFF);

  always_comb begin
    nextState = state;
    strobe    = '0;
    if (!enable) begin
      nextState       = S_IDLE;
      strobe.clearDac = 1'b1;
    end else if (state == S_IDLE) begin
      nextState       = S_DELAY;
      strobe.clearDac = 1'b1;
      strobe.loadCnt  = 1'b1;
      strobe.cntSel   = CNT_DELAY;
    end else if (state == S_OFF) begin
      strobe.clearDac = 1'b1;
      if (faultClr) nextState = S_IDLE;
    end else if (offCode) begin
      nextState       = S_OFF;
      strobe.clearDac = 1'b1;
    end else begin
      case (state)
        S_DELAY: begin
          if (cntZero) nextState = S_RAMP1;
        end
        S_RAMP1: begin
          if (atPlateau) begin
            nextState      = S_HOLD;
            strobe.loadCnt = 1'b1;
            strobe.cntSel  = CNT_HOLD;
          end else if (stepTick) begin
            strobe.stepUp = 1'b1;
          end
        end
        S_HOLD: begin
          if (cntZero && vidValid) nextState = S_RAMP2;
        end
        S_RAMP2: begin
          if (atTarget) begin
            nextState      = S_POST;
            strobe.loadCnt = 1'b1;
            strobe.cntSel  = CNT_POST;
          end else if (stepTick) begin
            strobe.stepUp   = belowTarget;
            strobe.stepDown = !belowTarget;
          end
        end
        S_POST: begin
          if (cntZero) nextState = S_READY;
        end
        default: nextState = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  assign ready      = (state == S_READY);
  assign ssActive   = seqBusy && (state != S_READY);
  assign forceCcm   = !ready;
  assign lowPwrMode = ready && psiReq;

  // R11
  enable_loss_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (dacCode == '0) && !ready);

  // R10
  off_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && seqBusy && offCode) |=> (dacCode == '0) && !ready && !ssActive);

  // R3
  step_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((dacCode != $past(dacCode)) && (dacCode != '0)) |-> $past(stepTick));

  // R4
  plateau_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RAMP1) |-> (dacCode <= CODE_W'(PLAT_CODE)));

endmodule

// File: rtl/vr_softstart_seq.sv
module vr_softstart_seq
  import ss_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int DELAY1_CYC = 136000,
  parameter int HOLD_CYC   = 8500,
  parameter int READY_CYC  = 8500,
  parameter int PLAT_CODE  = 176
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              vidValid,
  input  logic [CODE_W-1:0] vidCode,
  input  logic              stepTick,
  input  logic              faultClr,
  input  logic              psiReq,
  output logic [CODE_W-1:0] dacCode,
  output logic              ready,
  output logic              ssActive,
  output logic              forceCcm,
  output logic              lowPwrMode
);

  ssStrobe_t strobe;
  logic      cntZero;
  logic      atPlateau;
  logic      atTarget;
  logic      belowTarget;
  logic      offCode;

  ss_datapath #(
    .CODE_W    (CODE_W),
    .DELAY1_CYC(DELAY1_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .READY_CYC (READY_CYC),
    .PLAT_CODE (PLAT_CODE)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .vidValid   (vidValid),
    .vidCode    (vidCode),
    .dacCode    (dacCode),
    .cntZero    (cntZero),
    .atPlateau  (atPlateau),
    .atTarget   (atTarget),
    .belowTarget(belowTarget),
    .offCode    (offCode)
  );

  ss_ctrl #(
    .CODE_W   (CODE_W),
    .PLAT_CODE(PLAT_CODE)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .vidValid   (vidValid),
    .stepTick   (stepTick),
    .faultClr   (faultClr),
    .psiReq     (psiReq),
    .cntZero    (cntZero),
    .atPlateau  (atPlateau),
    .atTarget   (atTarget),
    .belowTarget(belowTarget),
    .offCode    (offCode),
    .dacCode    (dacCode),
    .strobe     (strobe),
    .ready      (ready),
    .ssActive   (ssActive),
    .forceCcm   (forceCcm),
    .lowPwrMode (lowPwrMode)
  );

endmodule

// File: tb/vr_softstart_seq_bench.sv
module vr_softstart_seq_bench;

  localparam int CODE_W = 8;
  localparam int D1     = 20;
  localparam int HOLD   = 10;
  localparam int RDY    = 12;
  localparam int PLAT   = 176;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              enable = 1'b0;
  logic              vidValid = 1'b0;
  logic [CODE_W-1:0] vidCode = '0;
  logic              stepTick = 1'b0;
  logic              faultClr = 1'b0;
  logic              psiReq = 1'b0;
  logic [CODE_W-1:0] dacCode;
  logic              ready, ssActive, forceCcm, lowPwrMode;

  int checks = 0;
  int errors = 0;
  int tickPer = 1;
  int tickCnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vr_softstart_seq #(
    .CODE_W(CODE_W), .DELAY1_CYC(D1), .HOLD_CYC(HOLD),
    .READY_CYC(RDY), .PLAT_CODE(PLAT)
  ) u_vr_softstart_seq (
    .clk(clk), .rstN(rstN), .enable(enable), .vidValid(vidValid),
    .vidCode(vidCode), .stepTick(stepTick), .faultClr(faultClr),
    .psiReq(psiReq), .dacCode(dacCode), .ready(ready),
    .ssActive(ssActive), .forceCcm(forceCcm), .lowPwrMode(lowPwrMode)
  );

  // Tick source: one pulse every tickPer cycles, driven at the falling edge.
  always @(negedge clk) begin
    if (tickCnt >= tickPer - 1) begin
      stepTick = 1'b1;
      tickCnt  = 0;
    end else begin
      stepTick = 1'b0;
      tickCnt  = tickCnt + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic waitDac(input int val, output int n);
    n = 0;
    while (dacCode != CODE_W'(val) && n < 2000) begin
      cyc();
      n++;
    end
  endtask

  task automatic waitReady(output int n);
    n = 0;
    while (!ready && n < 2000) begin
      cyc();
      n++;
    end
  endtask

  task automatic restart(input int per, input bit vv, input int vid);
    enable = 1'b0;
    cyc(); cyc();
    tickPer  = per;
    vidValid = vv;
    vidCode  = CODE_W'(vid);
    enable   = 1'b1;
  endtask

  task automatic testReset();
    check(dacCode == 0, "R1 dac in reset", int'(dacCode), 0);
    rstN = 1'b1;
    cyc(); cyc();
    check(!ready && !ssActive, "R1 ready/active idle", int'(ready) + int'(ssActive), 0);
    check(forceCcm == 1'b1, "R1 forceCcm idle", int'(forceCcm), 1);
  endtask

  task automatic testDelay();
    int n;
    restart(1, 1'b1, 240);
    cyc();
    check(ssActive == 1'b1, "R12 active after enable", int'(ssActive), 1);
    n = 1;
    while (dacCode == 0 && n < 500) begin
      cyc();
      n++;
    end
    check(n == D1 + 2, "R2 first step edge", n, D1 + 2);
  endtask

  task automatic testStepRate();
    int n;
    int prev;
    bit bad = 1'b0;
    restart(3, 1'b1, 240);
    waitDac(10, n);
    n = 0;
    prev = int'(dacCode);
    while (dacCode != 8'd20 && n < 500) begin
      cyc();
      n++;
      if (int'(dacCode) - prev > 1 || int'(dacCode) < prev) bad = 1'b1;
      prev = int'(dacCode);
    end
    check(n == 30, "R3 ten steps at tick period 3", n, 30);
    check(!bad, "R3 single-code increments", int'(bad), 0);
  endtask

  task automatic testPlateauAndReady();
    int n;
    restart(1, 1'b0, 240);
    waitDac(PLAT, n);
    repeat (40) cyc();
    check(dacCode == CODE_W'(PLAT), "R4 plateau hold", int'(dacCode), PLAT);
    check(ssActive && !ready, "R12 active on plateau", int'(ready), 0);
    psiReq = 1'b1;
    cyc();
    check(lowPwrMode == 1'b0, "R9 psi ignored before ready", int'(lowPwrMode), 0);
    check(forceCcm == 1'b1, "R9 forceCcm before ready", int'(forceCcm), 1);
    vidValid = 1'b1;
    waitDac(240, n);
    check(dacCode == 8'd240, "R6 ramp reaches target", int'(dacCode), 240);
    waitReady(n);
    check(n == RDY + 1, "R8 ready delay", n, RDY + 1);
    check(lowPwrMode == 1'b1 && forceCcm == 1'b0, "R9 psi honoured when ready",
          int'(lowPwrMode), 1);
    check(!ssActive, "R12 inactive when ready", int'(ssActive), 0);
    psiReq = 1'b0;
    enable = 1'b0;
    cyc();
    check(!ready && dacCode == 0, "R11 enable loss", int'(dacCode), 0);
    check(forceCcm && !ssActive, "R1 idle after enable loss", int'(ssActive), 0);
  endtask

  task automatic testHoldMin();
    int n;
    restart(1, 1'b1, 240);
    waitDac(PLAT, n);
    waitDac(PLAT + 1, n);
    check(n == HOLD + 2, "R5 plateau hold minimum", n, HOLD + 2);
  endtask

  task automatic testDownRamp();
    int n;
    int peak = 0;
    restart(1, 1'b1, 200);
    waitDac(PLAT, n);
    vidCode = 8'd170;
    n = 0;
    while (!ready && n < 500) begin
      cyc();
      n++;
      if (int'(dacCode) > peak) peak = int'(dacCode);
    end
    check(peak == PLAT, "R6 no overshoot above plateau", peak, PLAT);
    check(dacCode == 8'd170, "R6 ramp down to target", int'(dacCode), 170);
  endtask

  task automatic testLowTarget();
    int n;
    int peak = 0;
    restart(1, 1'b1, 100);
    waitDac(100, n);
    n = 0;
    while (!ready && n < 500) begin
      cyc();
      n++;
      if (int'(dacCode) > peak) peak = int'(dacCode);
    end
    check(peak == 100, "R7 first ramp capped at low target", peak, 100);
    check(n == HOLD + RDY + 2, "R7 zero-step second ramp", n, HOLD + RDY + 2);
  endtask

  task automatic testOffCode();
    int n;
    restart(1, 1'b1, 240);
    waitDac(50, n);
    check(stepTick == 1'b1, "R10 tick present at off code", int'(stepTick), 1);
    vidCode = 8'd0;
    cyc();
    check(dacCode == 0, "R10 off code beats tick", int'(dacCode), 0);
    check(!ssActive && !ready, "R10 sequence stopped", int'(ssActive), 0);
    vidCode = 8'd240;
    repeat (20) cyc();
    check(dacCode == 0 && !ssActive, "R10 latched after off code removed",
          int'(dacCode), 0);
    faultClr = 1'b1;
    cyc();
    faultClr = 1'b0;
    cyc();
    check(ssActive == 1'b1, "R10 restart after fault clear", int'(ssActive), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(); cyc();
    testReset();
    testDelay();
    testStepRate();
    testPlateauAndReady();
    testHoldMin();
    testDownRamp();
    testLowTarget();
    testOffCode();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule